// File: doc/BRIEF.md
# Slave Busy Capture and Internal Bus Arbiter

This block sits inside the slave side of a backplane bus interface. A user device can report that it is busy. The block captures that busy indication twice, through two cascaded gated holding stages. Each stage opens under its own condition. The first captured copy decides whether the slave asks for the shared internal address/data buses and whether a granted cycle may start. The second captured copy, taken from the first, is the one the status-response and transfer-abort logic uses.

The two stages open in different timing phases. The copy that steers arbitration can only drop while a cycle is in its late phase, so the shared address bus never sees two drivers at the start of a cycle. The status copy is taken in the early phase, so busy may be derived from the address of the current transfer. An optional input register holds the busy input through the early phase, so that a source asynchronous to the bus can drive it.

All four outputs are registered. They change on the rising clock edge that follows the inputs that cause the change. The two timing inputs `phase_a` and `phase_b` encode the phases:
- The early phase is `phase_a`=1, `phase_b`=0.
- The late phase is `phase_a`=0, `phase_b`=1.
- The other two codes are neither phase.

Top module: `busy_arb_gate`

## Requirements
- R1: While `rst_n` is 0, `arb_busy`, `stat_busy`, `bus_req` and `bus_own` are all 0.
- R2: The arbitration copy `arb_busy` loads the busy input at a clock edge when `grant_n` is 0, when `attached` is 0, or in the late phase (`phase_a`=0, `phase_b`=1). At any other edge it keeps its value, whatever the busy input does.
- R3: The status copy `stat_busy` loads the current `arb_busy` at a clock edge in the early phase (`phase_a`=1, `phase_b`=0) or when `attached` is 0. At any other edge it keeps its value.
- R4: `bus_req` is 1 whenever `arb_busy` is 0 and the request is armed, and it is 0 whenever `arb_busy` is 1. The request is armed after reset.
- R5: A 1-to-0 transition of `grant_n` while `arb_busy` is 0 sets `bus_own` to 1 at the next edge. `bus_own` then stays 1 while `grant_n` stays 0. The same transition while `arb_busy` is 1 leaves `bus_own` at 0.
- R6: When `grant_n` returns to 1 during ownership, `bus_own` and `bus_req` both go to 0 at the next edge, and the request is disarmed. It is re-armed only at an edge where the arbitration copy is open (R2) and loads a busy input of 0.
- R7: With parameter `IN_REG`=1, the busy input passes through one register that loads every cycle except in the early phase, where it holds. This adds one cycle of latency in front of the arbitration copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_in | input | 1 | Busy indication from the user device |
| grant_n | input | 1 | Active-low internal bus enable (grant) |
| attached | input | 1 | 1 while the slave is attached to the backplane master |
| phase_a | input | 1 | Timing phase code bit A |
| phase_b | input | 1 | Timing phase code bit B |
| bus_req | output | 1 | Request for the internal address/data buses |
| bus_own | output | 1 | 1 while the slave is using the internal buses |
| arb_busy | output | 1 | Busy copy used for arbitration |
| stat_busy | output | 1 | Busy copy used for status and abort |

## Verification
A busy input that changes while attached and idle shows whether the arbitration copy really holds outside the late phase. The same change made later in the late phase shows that it then follows. Early-phase cycles with different arbitration values set the status copy apart from the arbitration copy, and running detached shows both copies following in a one-cycle cascade. Grant sequences check three things: a cycle started with busy clear, a grant refused while busy, and a request that stays down after a cycle until the late phase re-evaluates busy. A second instance with the input register shows that busy is held through the early phase.

// File: rtl/busy_arb_pkg.sv
package busy_arb_pkg;

    // Registered state of the arbiter core.
    typedef struct packed {
        logic arb_busy;      // arbitration copy of busy
        logic stat_busy;     // status copy of busy
        logic armed;         // request allowed until next cycle end
        logic own;           // internal buses in use
        logic req;           // bus request
        logic grant_prev_n;  // grant_n seen at previous edge
    } arb_state_t;

    localparam arb_state_t ARB_RESET = '{
        arb_busy:     1'b0,
        stat_busy:    1'b0,
        armed:        1'b1,
        own:          1'b0,
        req:          1'b0,
        grant_prev_n: 1'b1
    };

endpackage

// File: rtl/busy_phase_decode.sv
// Decodes the two timing code bits into the early and late phase strobes.
module busy_phase_decode #(
    parameter logic EARLY_A = 1'b1,
    parameter logic EARLY_B = 1'b0
) (
    input  logic phase_a,
    input  logic phase_b,
    output logic strobe_early,
    output logic strobe_late
);
    // The late phase uses the complementary code of the early phase.
    localparam logic LATE_A = ~EARLY_A;
    localparam logic LATE_B = ~EARLY_B;

    always_comb begin
        strobe_early = (phase_a == EARLY_A) && (phase_b == EARLY_B);
        strobe_late  = (phase_a == LATE_A)  && (phase_b == LATE_B);
    end
endmodule

// File: rtl/busy_in_stage.sv
// Optional input register for the busy input. When it is in use it holds
// through the early phase, so a source asynchronous to the bus sees a stable
// capture window.
module busy_in_stage #(
    parameter bit IN_REG = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_in,
    input  logic hold,
    output logic busy_out
);
    logic hold_d, hold_q;

    always_comb begin
        hold_d = hold ? hold_q : busy_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold_d;
    end

    generate
        if (IN_REG) begin : g_reg
            assign busy_out = hold_q;
        end else begin : g_pass
            // The register is present but unused on this path.
            logic unused_q;
            assign unused_q = hold_q;
            assign busy_out = busy_in;
        end
    endgenerate
endmodule

// File: rtl/busy_arb_core.sv
// Two cascaded busy captures with gated load, bus request and cycle ownership.
module busy_arb_core
    import busy_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy_s,
    input  logic grant_n,
    input  logic attached,
    input  logic strobe_early,
    input  logic strobe_late,
    output logic bus_req,
    output logic bus_own,
    output logic arb_busy,
    output logic stat_busy
);
    arb_state_t st_d, st_q;

    logic open_arb;    // arbitration copy transparent
    logic open_stat;   // status copy transparent
    logic cyc_start;
    logic cyc_end;

    always_comb begin
        st_d = st_q;

        // The arbitration copy may only change while granted, while
        // detached, or late in the cycle.
        open_arb  = !grant_n || !attached || strobe_late;
        // The status copy follows the arbitration copy early in the cycle.
        open_stat = strobe_early || !attached;

        // A cycle starts on the falling edge of the grant, and only
        // when the arbitration copy is clear.
        cyc_start = st_q.grant_prev_n && !grant_n && !st_q.arb_busy && !st_q.own;
        cyc_end   = st_q.own && grant_n;

        if (open_arb)  st_d.arb_busy  = busy_s;
        if (open_stat) st_d.stat_busy = st_q.arb_busy;

        // After a cycle ends the request stays down until busy has been
        // evaluated again as clear.
        if (cyc_end)                   st_d.armed = 1'b0;
        else if (open_arb && !busy_s)  st_d.armed = 1'b1;

        if (cyc_start)    st_d.own = 1'b1;
        else if (grant_n) st_d.own = 1'b0;

        st_d.req          = st_d.armed && !st_d.arb_busy;
        st_d.grant_prev_n = grant_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ARB_RESET;
        else        st_q <= st_d;
    end

    assign bus_req   = st_q.req;
    assign bus_own   = st_q.own;
    assign arb_busy  = st_q.arb_busy;
    assign stat_busy = st_q.stat_busy;
endmodule

// File: rtl/busy_arb_gate.sv
module busy_arb_gate #(
    parameter bit IN_REG = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_in,
    input  logic grant_n,
    input  logic attached,
    input  logic phase_a,
    input  logic phase_b,
    output logic bus_req,
    output logic bus_own,
    output logic arb_busy,
    output logic stat_busy
);
    logic strobe_early;
    logic strobe_late;
    logic busy_s;

    busy_phase_decode i_phase (
        .phase_a      (phase_a),
        .phase_b      (phase_b),
        .strobe_early (strobe_early),
        .strobe_late  (strobe_late)
    );

    busy_in_stage #(.IN_REG(IN_REG)) i_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_in  (busy_in),
        .hold     (strobe_early),
        .busy_out (busy_s)
    );

    busy_arb_core i_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_s       (busy_s),
        .grant_n      (grant_n),
        .attached     (attached),
        .strobe_early (strobe_early),
        .strobe_late  (strobe_late),
        .bus_req      (bus_req),
        .bus_own      (bus_own),
        .arb_busy     (arb_busy),
        .stat_busy    (stat_busy)
    );
endmodule

// File: rtl/busy_arb_checker.sv
module busy_arb_checker (
    input logic clk,
    input logic rst_n,
    input logic grant_n,
    input logic attached,
    input logic phase_a,
    input logic phase_b,
    input logic bus_req,
    input logic bus_own,
    input logic arb_busy,
    input logic stat_busy
);
    // R2: closed arbitration copy keeps its value
    a_r2_arb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (attached && grant_n && !(!phase_a && phase_b)) |=> $stable(arb_busy));

    // R3: closed status copy keeps its value
    a_r3_stat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (attached && !(phase_a && !phase_b)) |=> $stable(stat_busy));

    // R3: early phase loads status copy from arbitration copy
    a_r3_stat_load: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_a && !phase_b) |=> (stat_busy == $past(arb_busy)));

    // R4: never request while busy
    a_r4_busy_noreq: assert property (@(posedge clk) disable iff (!rst_n)
        arb_busy |-> !bus_req);

    // R5: ownership persists while granted
    a_r5_own_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_own && !grant_n) |=> bus_own);

    // R5: no cycle starts while busy
    a_r5_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_own && arb_busy) |=> !bus_own);

    // R6: grant release ends ownership and request
    a_r6_end: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_own && grant_n) |=> (!bus_own && !bus_req));
endmodule

bind busy_arb_gate busy_arb_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant_n   (grant_n),
    .attached  (attached),
    .phase_a   (phase_a),
    .phase_b   (phase_b),
    .bus_req   (bus_req),
    .bus_own   (bus_own),
    .arb_busy  (arb_busy),
    .stat_busy (stat_busy)
);

// File: tb/test_busy_arb_gate.sv
module test_busy_arb_gate;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 22;

    // {busy, grant_n, attached, phase_a, phase_b, req, own, arb, stat}
    localparam logic [8:0] VEC [NVEC] = '{
        9'b01100_1000,  // idle, request armed
        9'b11100_1000,  // busy rises, copy closed (R2)
        9'b11101_0010,  // late phase: copy loads 1, request drops
        9'b11110_0011,  // early phase: status loads (R3)
        9'b01100_0011,  // busy clears, copy closed
        9'b01101_1001,  // late phase: copy clears, request back
        9'b01110_1000,  // early phase: status clears
        9'b00100_1100,  // grant falls: cycle starts (R5)
        9'b10100_0110,  // busy during grant: copy open
        9'b01100_0010,  // grant released: cycle ends (R6)
        9'b01101_1000,  // late phase: re-armed
        9'b00100_1100,  // second cycle
        9'b01100_0000,  // end, disarmed (R6)
        9'b01100_0000,  // still no request (R6)
        9'b01101_1000,  // late phase re-arms (R6)
        9'b11000_0010,  // detached: both open
        9'b11000_0011,
        9'b01000_1001,
        9'b01000_1000,
        9'b11101_0010,  // busy captured
        9'b10100_0010,  // grant falls while busy: no start (R5)
        9'b11100_0010
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic busy_in = 1'b0, grant_n = 1'b1, attached = 1'b1, phase_a = 1'b0, phase_b = 1'b0;
    logic bus_req, bus_own, arb_busy, stat_busy;
    logic r_busy = 1'b0, r_pa = 1'b0, r_pb = 1'b0;
    logic r_req, r_own, r_arb, r_stat;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    busy_arb_gate i_busy_arb_gate (
        .clk(clk), .rst_n(rst_n), .busy_in(busy_in), .grant_n(grant_n),
        .attached(attached), .phase_a(phase_a), .phase_b(phase_b),
        .bus_req(bus_req), .bus_own(bus_own), .arb_busy(arb_busy), .stat_busy(stat_busy)
    );

    busy_arb_gate #(.IN_REG(1'b1)) i_busy_arb_gate_reg (
        .clk(clk), .rst_n(rst_n), .busy_in(r_busy), .grant_n(1'b1),
        .attached(1'b0), .phase_a(r_pa), .phase_b(r_pb),
        .bus_req(r_req), .bus_own(r_own), .arb_busy(r_arb), .stat_busy(r_stat)
    );

    task automatic check(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        check(bus_req, 1'b0, "R1 bus_req in reset");
        check(bus_own, 1'b0, "R1 bus_own in reset");
        check(arb_busy, 1'b0, "R1 arb_busy in reset");
        check(stat_busy, 1'b0, "R1 stat_busy in reset");
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            {busy_in, grant_n, attached, phase_a, phase_b} = VEC[i][8:4];
            @(negedge clk);
            check(bus_req,   VEC[i][3], $sformatf("R4 R6 bus_req step %0d", i));
            check(bus_own,   VEC[i][2], $sformatf("R5 R6 bus_own step %0d", i));
            check(arb_busy,  VEC[i][1], $sformatf("R2 arb_busy step %0d", i));
            check(stat_busy, VEC[i][0], $sformatf("R3 stat_busy step %0d", i));
        end

        // R1: reset from a busy state clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check(arb_busy, 1'b0, "R1 arb_busy after mid-run reset");
        check(stat_busy, 1'b0, "R1 stat_busy after mid-run reset");
        check(bus_req, 1'b0, "R1 bus_req after mid-run reset");
        rst_n = 1'b1;

        // R7: registered input holds through the early phase
        r_busy = 1'b1; r_pa = 1'b1; r_pb = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(r_arb, 1'b0, "R7 busy held during early phase");
        r_pa = 1'b0;
        @(negedge clk);
        check(r_arb, 1'b0, "R7 extra cycle of latency");
        @(negedge clk);
        check(r_arb, 1'b1, "R7 busy reaches arbitration copy");
        check(r_req, 1'b0, "R7 R4 request dropped behind register");

        summary();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule